// File: doc/BRIEF.md
# Single-Cycle Signed ALU with Start/Done Handshake

This block is an 8-bit two's-complement arithmetic and logic unit. A requester presents two signed operands, a 4-bit operation code and a one-cycle `start_i` pulse. On the next clock edge the unit captures the answer into its output registers and raises `done_o` for one cycle. The answer is an 8-bit result plus a ninth output bit, `carry_o`.

The operations are grouped as follows:

- **Arithmetic:** sums, both differences and both negations.
- **Pass-through:** either operand is copied to the result.
- **Shift and rotate:** logical shifts and rotates of operand A by one place.
- **Constant fills:** all-zeros and all-ones.

For arithmetic and pass-through, both operands are sign-extended to nine bits. The result register takes the low eight bits of that nine-bit result and `carry_o` takes its top bit. As a result, `carry_o` is set whenever such a result is negative. Shifts and rotates have their own carry rules. Three codes are unused, and those codes produce zero on both outputs.

A small two-state controller sequences the handshake:

- **States:** `ST_IDLE` (no answer pending) and `ST_ANSWER` (an answer is on the outputs this cycle).
- **Transitions:**
  - "request": `start_i` high moves the controller to `ST_ANSWER` from either state.
  - "retire": `start_i` low moves it to `ST_IDLE` from either state.
  - "reset": `rst_i` forces `ST_IDLE`.
- **Output update:** the result registers load only on a request edge. Between requests they hold their last answer.

Top module: `sc_alu`

## Requirements
- R1: While `rst_i` (synchronous, active high) is sampled high, the next clock edge clears `result_o`, `carry_o` and `done_o` to 0.
- R2: Codes 0000 (A+B), 0001 (A−B) and 0010 (B−A) compute on the 9-bit sign extensions of the operands. `result_o` receives bits 7:0 of the result and `carry_o` receives bit 8.
- R3: Codes 0100 (pass A), 0101 (pass B), 0110 (−A) and 0111 (−B) follow the same 9-bit sign-extended rule. Pass-through therefore gives `carry_o` equal to the operand's bit 7.
- R4: Code 1000 (shift left) gives {A[6:0],0} with `carry_o` = A[7]. Code 1001 (shift right) gives {0,A[7:1]} with `carry_o` = 0.
- R5: Code 1010 (rotate left) gives {A[6:0],A[7]} with `carry_o` = A[7]. Code 1011 (rotate right) gives {A[0],A[7:1]} with `carry_o` = 0.
- R6: Code 1110 gives result 8'h00 with `carry_o` = 0. Code 1111 gives result 8'hFF with `carry_o` = 1.
- R7: The unused codes 0011, 1100 and 1101 give result 0 and `carry_o` = 0.
- R8: `done_o` is high in exactly those cycles that follow a cycle in which `start_i` was sampled high. In those cycles it carries the answer for the operands and code sampled with that `start_i`.
- R9: When `start_i` is sampled low, `result_o` and `carry_o` keep their values, whatever the operands and code do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request; operands and code are sampled with it |
| opa_i | input | 8 | Signed operand A |
| opb_i | input | 8 | Signed operand B |
| opcode_i | input | 4 | Operation code |
| result_o | output | 8 | Registered result |
| carry_o | output | 1 | Registered ninth bit / shift carry |
| done_o | output | 1 | One-cycle answer strobe |

## Verification
The bench builds the unit with its default width of 8. This lets it drive the signed extremes of the datapath: +127, −128, −1 and 0. With those operands the bench can check overflow wrapping into `carry_o`, such as 127+1 giving 8'h80 with carry 0 and the negation of −128. Directed requests cover every code, including the three unused ones. Idle stretches with moving operands confirm the hold rule, and back-to-back requests confirm the strobe timing. A long pseudo-random run with a behavioural reference updated on every edge exercises all codes against random request gaps.

// File: rtl/sc_alu_pkg.sv
package sc_alu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 4'b0000,
        OP_SUBA = 4'b0001,
        OP_SUBB = 4'b0010,
        OP_PSA  = 4'b0100,
        OP_PSB  = 4'b0101,
        OP_NGA  = 4'b0110,
        OP_NGB  = 4'b0111,
        OP_SHL  = 4'b1000,
        OP_SHR  = 4'b1001,
        OP_ROL  = 4'b1010,
        OP_ROR  = 4'b1011,
        OP_ZERO = 4'b1110,
        OP_ONES = 4'b1111
    } alu_op_e;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ANSWER = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/sc_alu_arith.sv
module sc_alu_arith
    import sc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic [OPC_W-1:0] op_i,
    output logic [W-1:0]     res_o,
    output logic             msb_o,
    output logic             hit_o
);
    localparam int XW = W + 1;

    logic [XW-1:0] ax, bx, sum;

    assign ax = {a_i[W-1], a_i};
    assign bx = {b_i[W-1], b_i};

    always_comb begin
        sum   = '0;
        hit_o = 1'b1;
        unique case (op_i)
            OP_ADD:  sum = ax + bx;
            OP_SUBA: sum = ax - bx;
            OP_SUBB: sum = bx - ax;
            OP_PSA:  sum = ax;
            OP_PSB:  sum = bx;
            OP_NGA:  sum = '0 - ax;
            OP_NGB:  sum = '0 - bx;
            default: hit_o = 1'b0;
        endcase
    end

    assign res_o = sum[W-1:0];
    assign msb_o = sum[XW-1];

endmodule

// File: rtl/sc_alu_shift.sv
module sc_alu_shift
    import sc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]     a_i,
    input  logic [OPC_W-1:0] op_i,
    output logic [W-1:0]     res_o,
    output logic             out_bit_o,
    output logic             hit_o
);
    always_comb begin
        res_o     = '0;
        out_bit_o = 1'b0;
        hit_o     = 1'b1;
        unique case (op_i)
            OP_SHL: begin
                res_o     = {a_i[W-2:0], 1'b0};
                out_bit_o = a_i[W-1];
            end
            OP_SHR: res_o = {1'b0, a_i[W-1:1]};
            OP_ROL: begin
                res_o     = {a_i[W-2:0], a_i[W-1]};
                out_bit_o = a_i[W-1];
            end
            OP_ROR: res_o = {a_i[0], a_i[W-1:1]};
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
    import sc_alu_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic load_o,
    output logic done_o
);
    ctrl_state_e state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ANSWER;
            ST_ANSWER: if (!start_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o = start_i;
        done_o = (state_q == ST_ANSWER);
    end

    // R8: every strobe is preceded by a request, every request answered
    assert_done_after_start_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> $past(start_i));
    assert_start_answered_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> done_o);

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [W-1:0]     opa_i,
    input  logic [W-1:0]     opb_i,
    input  logic [OPC_W-1:0] opcode_i,
    output logic [W-1:0]     result_o,
    output logic             carry_o,
    output logic             done_o
);
    logic [W-1:0] ar_res, sh_res, sel_res;
    logic         ar_msb, ar_hit, sh_bit, sh_hit, sel_bit, load;

    sc_alu_arith #(.W(W)) i_arith (
        .a_i(opa_i), .b_i(opb_i), .op_i(opcode_i),
        .res_o(ar_res), .msb_o(ar_msb), .hit_o(ar_hit)
    );

    sc_alu_shift #(.W(W)) i_shift (
        .a_i(opa_i), .op_i(opcode_i),
        .res_o(sh_res), .out_bit_o(sh_bit), .hit_o(sh_hit)
    );

    sc_alu_ctrl i_ctrl (
        .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i),
        .load_o(load), .done_o(done_o)
    );

    always_comb begin
        if (ar_hit) begin
            sel_res = ar_res;
            sel_bit = ar_msb;
        end else if (sh_hit) begin
            sel_res = sh_res;
            sel_bit = sh_bit;
        end else if (opcode_i == OP_ONES) begin
            sel_res = '1;
            sel_bit = 1'b1;
        end else begin
            sel_res = '0;
            sel_bit = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            result_o <= '0;
            carry_o  <= 1'b0;
        end else if (load) begin
            result_o <= sel_res;
            carry_o  <= sel_bit;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk_i)
        rst_i |=> (result_o == '0 && !carry_o && !done_o));
    assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !start_i |=> ($stable(result_o) && $stable(carry_o)));
    assert_shr_ror_carry_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && (opcode_i == OP_SHR || opcode_i == OP_ROR)) |=> !carry_o);
    assert_ones_fill_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && opcode_i == OP_ONES) |=> (result_o == '1 && carry_o));
    assert_unused_zero_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && (opcode_i == 4'b0011 || opcode_i == 4'b1100 || opcode_i == 4'b1101))
        |=> (result_o == '0 && !carry_o));

endmodule

// File: tb/test_sc_alu.sv
module test_sc_alu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] a = '0, b = '0;
    logic [3:0] op = '0;
    logic [7:0] res;
    logic       cy, dn;

    int n_run = 0, n_fail = 0;
    int exp_f = 0, exp_c = 0, exp_d = 0;
    string exp_tag = "R1";
    bit seen_edge = 1'b0;

    always #2.5 clk = ~clk;

    sc_alu i_sc_alu (
        .clk_i(clk), .rst_i(rst), .start_i(start),
        .opa_i(a), .opb_i(b), .opcode_i(op),
        .result_o(res), .carry_o(cy), .done_o(dn)
    );

    function automatic string tag_of(input int o);
        case (o)
            0, 1, 2:       return "R2";
            4, 5, 6, 7:    return "R3";
            8, 9:          return "R4";
            10, 11:        return "R5";
            14, 15:        return "R6";
            default:       return "R7";
        endcase
    endfunction

    // behavioural reference: returns {carry, result} as an integer
    function automatic int model(input int ua, input int ub, input int o);
        int sa, sb, r;
        sa = (ua > 127) ? ua - 256 : ua;
        sb = (ub > 127) ? ub - 256 : ub;
        case (o)
            0: r = sa + sb;
            1: r = sa - sb;
            2: r = sb - sa;
            4: r = sa;
            5: r = sb;
            6: r = -sa;
            7: r = -sb;
            8:  return ((ua / 128) * 256) + ((ua * 2) % 256);
            9:  return ua / 2;
            10: return ((ua / 128) * 256) + ((ua * 2) % 256) + (ua / 128);
            11: return (ua / 2) + ((ua % 2) * 128);
            14: return 0;
            15: return 511;
            default: return 0;
        endcase
        if (r < 0) r = r + 512;
        return r;
    endfunction

    always @(posedge clk) begin
        int m;
        seen_edge <= 1'b1;
        if (rst) begin
            exp_f <= 0; exp_c <= 0; exp_d <= 0; exp_tag <= "R1";
        end else begin
            exp_d <= start;
            if (start) begin
                m = model(a, b, op);
                exp_f   <= m % 256;
                exp_c   <= m / 256;
                exp_tag <= tag_of(op);
            end else begin
                exp_tag <= "R9";
            end
        end
    end

    always @(negedge clk) begin
        if (seen_edge) begin
            n_run += 3;
            if (res != exp_f[7:0]) begin
                n_fail++;
                $display("FAIL %s result: actual %0h expected %0h", exp_tag, res, exp_f[7:0]);
            end
            if (cy != exp_c[0]) begin
                n_fail++;
                $display("FAIL %s carry: actual %0b expected %0b", exp_tag, cy, exp_c[0]);
            end
            if (dn != exp_d[0]) begin
                n_fail++;
                $display("FAIL R8 done: actual %0b expected %0b", dn, exp_d[0]);
            end
        end
    end

    task automatic req(input int ua, input int ub, input int o);
        @(negedge clk);
        a = ua[7:0]; b = ub[7:0]; op = o[3:0]; start = 1'b1;
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            start = 1'b0; a = a + 8'd37; b = b ^ 8'h5A; op = op + 4'd3;
        end
    endtask

    initial begin
        int lcg;
        repeat (3) @(negedge clk);           // R1 reset values checked here
        rst = 1'b0;
        // R2 arithmetic corners
        req(1, 2, 0); req(2, 3, 1); req(127, 1, 0); req(128, 128, 0);
        req(128, 127, 1); req(5, 255, 2); idle(2);
        // R3 pass and negate, including -128
        req(128, 0, 4); req(0, 127, 5); req(128, 0, 6); req(0, 1, 7); req(0, 0, 6); idle(1);
        // R4 / R5 shifts and rotates
        req(128, 0, 8); req(129, 0, 9); req(129, 0, 10); req(129, 0, 11);
        req(127, 0, 8); req(1, 0, 11); idle(1);
        // R6 fills, R7 unused codes
        req(200, 3, 14); req(9, 9, 15); req(255, 255, 3);
        req(255, 255, 15); req(77, 1, 12); req(255, 255, 15); req(4, 4, 13);
        idle(4);                              // R9 hold with moving inputs
        // R8 back-to-back then gaps, pseudo-random over all codes
        lcg = 12345;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            a = lcg[7:0]; b = lcg[15:8]; op = lcg[19:16]; start = lcg[21] | lcg[22];
        end
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;                           // R1 mid-run reset
        repeat (2) @(negedge clk);
        #1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule